// File: doc/BRIEF.md
# UART Receive Data Buffer

This block sits between a UART deserializer and a bus read port. Each time the deserializer finishes a character it raises a one-cycle strobe with the 8-bit value. The block stores the value in one of two run-time selectable ways. With the FIFO off, a single holding register keeps the latest character. With the FIFO on, a receive queue keeps the characters in arrival order.

A bus master reads the buffered character through the main buffer word, or through any of a window of sixteen consecutive word addresses that all map to the same buffer. A burst across that window therefore drains successive characters. The block drives two flags toward the line status logic. One is a data-ready flag. The other is a sticky overrun flag, which is cleared by a line-status read strobe.

The two modes handle overrun differently. In single-register mode the newest character replaces the unread one. In FIFO mode a full queue keeps what it holds and discards the newcomer. Either event raises the overrun flag.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, `rd_data` reads 0x00000000 at the buffer word, and both `data_ready` and `overrun_err` are 0.
- R2: A read of a buffer address presents the character in bits 7:0 of `rd_data`, with bits 31:8 at zero.
- R3: Word address 0 and word addresses 12 to 27 all reach the buffer. There, `rd_data` shows the oldest unread character, and `rd_en` consumes it at the clock edge. Any other address reads 0x00000000 and `rd_en` there consumes nothing.
- R4: `data_ready` is 1 while at least one unread character is held, and returns to 0 once the last one is consumed. A read while nothing is held changes no state.
- R5: With `fifo_en` = 0, a character arriving while an unread one is held replaces it, and `overrun_err` becomes 1 after that edge.
- R6: With `fifo_en` = 1, reads return characters oldest first, each read removing one.
- R7: With `fifo_en` = 1 the queue holds 16 characters. A character arriving while it is full and not being read is discarded, the stored characters stay unchanged, and `overrun_err` becomes 1.
- R8: A character that arrives in the same cycle as a consuming read of a full buffer (held register or full queue) is stored and raises no overrun.
- R9: `overrun_err` stays 1 until a cycle with `lsr_rd` = 1, after which it reads 0. If a new overrun occurs in that same cycle, the flag stays 1.
- R10: In a cycle where `fifo_en` differs from its value in the previous cycle, all held characters are discarded, a character arriving in that cycle is dropped, and `data_ready` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a finished character is on `rx_data` |
| rx_data | input | 8 | Received character |
| fifo_en | input | 1 | 1 selects queue operation, 0 selects single-register operation |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 6 | Bus word address |
| rd_data | output | 32 | Read word, character in bits 7:0 |
| lsr_rd | input | 1 | Line status read strobe, clears the overrun flag |
| data_ready | output | 1 | At least one unread character is held |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
The bench uses the default parameters: a 16-entry queue, a 6-bit word address, the main word at 0, and the alias window at words 12 to 27. With these values, sixteen strobes fill the queue, so the full-queue drop and the read-while-full case take only a few dozen cycles. A burst over all sixteen aliases then drains the queue exactly. Words 5 and 28 are used to check that addresses just outside the window do not read or consume the buffer.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    typedef logic [BYTE_W-1:0] rx_byte_t;
endpackage

// File: rtl/uart_rxb_decode.sv
module uart_rxb_decode #(
    parameter int ADDR_W       = 6,
    parameter int RBR_WORD     = 0,
    parameter int SHADOW_BASE  = 12,
    parameter int SHADOW_COUNT = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [SHADOW_COUNT-1:0] alias_hit;

    // one comparator per alias word
    for (genvar i = 0; i < SHADOW_COUNT; i++) begin : g_alias
        assign alias_hit[i] = (addr == ADDR_W'(SHADOW_BASE + i));
    end

    assign hit = (addr == ADDR_W'(RBR_WORD)) || (|alias_hit);
endmodule

// File: rtl/uart_rxb_hold.sv
module uart_rxb_hold
    import uart_rxb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     wr,
    input  rx_byte_t wr_byte,
    input  logic     rd,
    output rx_byte_t head,
    output logic     full,
    output logic     ovr_evt
);
    typedef struct packed {
        rx_byte_t data;
        logic     full;
    } hold_state_t;

    hold_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        ovr_evt = 1'b0;
        if (flush) begin
            s_d.full = 1'b0;
        end else begin
            if (rd) begin
                s_d.full = 1'b0;
            end
            if (wr) begin
                // an unread byte is lost unless it is being read now
                ovr_evt  = s_q.full && !rd;
                s_d.data = wr_byte;
                s_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head = s_q.data;
    assign full = s_q.full;

    // R5: overwrite keeps the newest byte
    a_r5_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !rd && !flush) |=> (full && head == $past(wr_byte)));
endmodule

// File: rtl/uart_rxb_fifo.sv
module uart_rxb_fifo
    import uart_rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr,
    input  rx_byte_t         wr_byte,
    input  logic             rd,
    output rx_byte_t         head,
    output logic [CNT_W-1:0] count,
    output logic             ovr_evt
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic        do_wr, do_rd;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_rd   = rd && (s_q.cnt != '0);
        // a pop in the same cycle frees the slot for the arrival
        do_wr   = wr && ((s_q.cnt != CNT_W'(DEPTH)) || do_rd);
        ovr_evt = wr && !do_wr;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
            ovr_evt = 1'b0;
        end else begin
            if (do_wr) begin
                s_d.mem[s_q.wp] = wr_byte;
                s_d.wp          = ptr_inc(s_q.wp);
            end
            if (do_rd) begin
                s_d.rp = ptr_inc(s_q.rp);
            end
            case ({do_wr, do_rd})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;

    // R7: occupancy never exceeds the depth
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7: a full queue without a pop keeps its contents
    a_r7_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && !flush && count == CNT_W'(DEPTH))
            |=> ($stable(s_q.mem) && count == CNT_W'(DEPTH)));

    // R6: a lone pop removes exactly one entry
    a_r6_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !flush && count != '0)
            |=> (count == CNT_W'($past(count) - 1'b1)));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxb_pkg::*;
#(
    parameter int FIFO_DEPTH   = 16,
    parameter int ADDR_W       = 6,
    parameter int RBR_WORD     = 0,
    parameter int SHADOW_BASE  = 12,
    parameter int SHADOW_COUNT = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              fifo_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              lsr_rd,
    output logic              data_ready,
    output logic              overrun_err
);
    typedef struct packed {
        logic mode;
        logic ovr;
    } top_state_t;

    top_state_t       s_d, s_q;
    logic             hit, flush, pop;
    logic             hold_wr, hold_rd, hold_full, hold_ovr;
    logic             fifo_wr, fifo_rd, fifo_ovr;
    rx_byte_t         hold_head, fifo_head, head;
    logic [CNT_W-1:0] fifo_cnt;

    uart_rxb_decode #(
        .ADDR_W      (ADDR_W),
        .RBR_WORD    (RBR_WORD),
        .SHADOW_BASE (SHADOW_BASE),
        .SHADOW_COUNT(SHADOW_COUNT)
    ) u_decode (
        .addr(rd_addr),
        .hit (hit)
    );

    always_comb begin
        flush   = (fifo_en != s_q.mode);
        pop     = rd_en && hit && !flush;
        hold_wr = rx_valid && !flush && !s_q.mode;
        fifo_wr = rx_valid && !flush &&  s_q.mode;
        hold_rd = pop && !s_q.mode;
        fifo_rd = pop &&  s_q.mode;
        s_d      = s_q;
        s_d.mode = fifo_en;
        // a new overrun wins over a clear in the same cycle
        s_d.ovr  = hold_ovr || fifo_ovr || (s_q.ovr && !lsr_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    uart_rxb_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr     (hold_wr),
        .wr_byte(rx_data),
        .rd     (hold_rd),
        .head   (hold_head),
        .full   (hold_full),
        .ovr_evt(hold_ovr)
    );

    uart_rxb_fifo #(
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr     (fifo_wr),
        .wr_byte(rx_data),
        .rd     (fifo_rd),
        .head   (fifo_head),
        .count  (fifo_cnt),
        .ovr_evt(fifo_ovr)
    );

    assign head        = s_q.mode ? fifo_head : hold_head;
    assign rd_data     = hit ? {{(WORD_W-BYTE_W){1'b0}}, head} : '0;
    assign data_ready  = s_q.mode ? (fifo_cnt != '0) : hold_full;
    assign overrun_err = s_q.ovr;

    // R9: the flag holds until a status read
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_err && !lsr_rd) |=> overrun_err);

    // R5: an overwrite in register mode raises the flag
    a_r5_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.mode && !flush && rx_valid && data_ready && !pop) |=> overrun_err);

    // R10: a mode change leaves nothing ready
    a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !data_ready);
endmodule

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        fifo_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        lsr_rd = 1'b0;
    logic        data_ready;
    logic        overrun_err;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_buffer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .fifo_en    (fifo_en),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .lsr_rd     (lsr_rd),
        .data_ready (data_ready),
        .overrun_err(overrun_err)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       wr;
        logic [7:0] b;
        logic       rd;
        logic [5:0] a;
        logic       lsr;
        logic [7:0] exp_data;
        logic       exp_dr;
        logic       exp_oe;
    } vec_t;

    // register mode; exp_data sampled before the edge, flags after it
    localparam vec_t VECS [15] = '{
        '{4'd1,  1'b0, 8'h00, 1'b0, 6'd0,  1'b0, 8'h00, 1'b0, 1'b0}, // R1 idle
        '{4'd4,  1'b1, 8'hA5, 1'b0, 6'd0,  1'b0, 8'h00, 1'b1, 1'b0}, // R4 set
        '{4'd4,  1'b0, 8'h00, 1'b1, 6'd0,  1'b0, 8'hA5, 1'b0, 1'b0}, // R4 clear
        '{4'd2,  1'b1, 8'h3C, 1'b0, 6'd0,  1'b0, 8'hA5, 1'b1, 1'b0}, // R2
        '{4'd5,  1'b1, 8'h5A, 1'b0, 6'd0,  1'b0, 8'h3C, 1'b1, 1'b1}, // R5
        '{4'd5,  1'b0, 8'h00, 1'b0, 6'd0,  1'b0, 8'h5A, 1'b1, 1'b1}, // R5 newest
        '{4'd9,  1'b0, 8'h00, 1'b0, 6'd0,  1'b1, 8'h5A, 1'b1, 1'b0}, // R9 clear
        '{4'd3,  1'b0, 8'h00, 1'b1, 6'd5,  1'b0, 8'h00, 1'b1, 1'b0}, // R3 miss
        '{4'd3,  1'b0, 8'h00, 1'b1, 6'd12, 1'b0, 8'h5A, 1'b0, 1'b0}, // R3 alias lo
        '{4'd4,  1'b1, 8'h11, 1'b1, 6'd27, 1'b0, 8'h5A, 1'b1, 1'b0}, // R4 empty rd
        '{4'd8,  1'b1, 8'h22, 1'b1, 6'd27, 1'b0, 8'h11, 1'b1, 1'b0}, // R8
        '{4'd9,  1'b1, 8'h33, 1'b0, 6'd0,  1'b1, 8'h22, 1'b1, 1'b1}, // R9 race
        '{4'd9,  1'b0, 8'h00, 1'b0, 6'd0,  1'b1, 8'h33, 1'b1, 1'b0}, // R9
        '{4'd3,  1'b0, 8'h00, 1'b1, 6'd28, 1'b0, 8'h00, 1'b1, 1'b0}, // R3 past
        '{4'd3,  1'b0, 8'h00, 1'b1, 6'd0,  1'b0, 8'h33, 1'b0, 1'b0}  // R3 main
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] b, input logic rd,
                         input logic [5:0] a, input logic lsr, input logic fen);
        @(negedge clk);
        rx_valid = wr; rx_data = b; rd_en = rd; rd_addr = a;
        lsr_rd = lsr; fifo_en = fen;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rd_en = 1'b0; lsr_rd = 1'b0; rd_addr = '0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state while in reset and right after release
        chk("R1", "rd_data", rd_data, 32'h0);
        chk("R1", "ready", {31'b0, data_ready}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1", "overrun", {31'b0, overrun_err}, 32'h0);

        foreach (VECS[i]) begin
            drive(VECS[i].wr, VECS[i].b, VECS[i].rd, VECS[i].a, VECS[i].lsr, 1'b0);
            chk($sformatf("R%0d", VECS[i].req), "rd_data", rd_data, {24'h0, VECS[i].exp_data});
            tick();
            chk($sformatf("R%0d", VECS[i].req), "ready", {31'b0, data_ready}, {31'b0, VECS[i].exp_dr});
            chk($sformatf("R%0d", VECS[i].req), "overrun", {31'b0, overrun_err}, {31'b0, VECS[i].exp_oe});
        end

        // R10: switch to queue mode with a byte held and one arriving
        drive(1'b1, 8'h44, 1'b0, 6'd0, 1'b0, 1'b0);
        tick();
        chk("R10", "ready before", {31'b0, data_ready}, 32'h1);
        drive(1'b1, 8'h55, 1'b0, 6'd0, 1'b0, 1'b1);
        tick();
        chk("R10", "ready after switch", {31'b0, data_ready}, 32'h0);

        // R7: fill sixteen entries
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, 8'h80 + 8'(i), 1'b0, 6'd0, 1'b0, 1'b1);
            tick();
        end
        chk("R7", "ready when full", {31'b0, data_ready}, 32'h1);
        chk("R7", "no overrun at 16", {31'b0, overrun_err}, 32'h0);
        drive(1'b1, 8'hEE, 1'b0, 6'd0, 1'b0, 1'b1);
        tick();
        chk("R7", "overrun on full", {31'b0, overrun_err}, 32'h1);
        drive(1'b0, 8'h00, 1'b0, 6'd0, 1'b1, 1'b1);
        tick();
        chk("R9", "cleared", {31'b0, overrun_err}, 32'h0);

        // R8: arrival alongside a pop of a full queue
        drive(1'b1, 8'hEF, 1'b1, 6'd0, 1'b0, 1'b1);
        chk("R6", "head", rd_data, 32'h80);
        tick();
        chk("R8", "no overrun", {31'b0, overrun_err}, 32'h0);

        // R3 R6: burst over the alias window drains in order
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, 8'h00, 1'b1, 6'(12 + i), 1'b0, 1'b1);
            chk("R6", $sformatf("burst %0d", i), rd_data,
                (i < 15) ? 32'(8'h81 + 8'(i)) : 32'hEF);
            tick();
        end
        chk("R4", "ready after drain", {31'b0, data_ready}, 32'h0);

        // R4: read of an empty queue, then a fresh byte
        drive(1'b0, 8'h00, 1'b1, 6'd0, 1'b0, 1'b1);
        tick();
        chk("R4", "empty read ready", {31'b0, data_ready}, 32'h0);
        drive(1'b1, 8'h09, 1'b0, 6'd0, 1'b0, 1'b1);
        tick();
        drive(1'b0, 8'h00, 1'b0, 6'd20, 1'b0, 1'b1);
        chk("R4", "fresh byte", rd_data, 32'h09);
        tick();
        chk("R4", "ready fresh", {31'b0, data_ready}, 32'h1);

        // R10: back to register mode drops the queue
        drive(1'b0, 8'h00, 1'b0, 6'd0, 1'b0, 1'b0);
        tick();
        chk("R10", "ready after return", {31'b0, data_ready}, 32'h0);

        // R1: reset while a byte is held
        drive(1'b1, 8'h77, 1'b0, 6'd0, 1'b0, 1'b0);
        tick();
        rst_n = 1'b0;
        #1;
        chk("R1", "rd_data after reset", rd_data, 32'h0);
        chk("R1", "ready after reset", {31'b0, data_ready}, 32'h0);

        finish_run();
    end
endmodule